// File: doc/BRIEF.md
# Transmit Descriptor Gather and Checksum Engine

This block empties a transmit descriptor ring kept in system memory. Each ring entry is eight bytes long: a 32-bit status word followed by the byte address of a data fragment. After a kick, the engine reads descriptors starting at the current ring index. It keeps going as long as the hardware-owned bit is set in the descriptor it reads. It copies each fragment into a 2048-byte staging buffer. If the descriptors ask for it, it computes a 16-bit ones-complement checksum and writes it into the frame. It then sends the finished frame out as a byte stream, hands the descriptor back by clearing its owned bit, and moves the ring index forward.

All memory traffic goes through one word-wide port. Read data returns on the cycle after the request, and the port never stalls. Frames leave on a valid/ready byte stream:
- A byte moves on each cycle where `out_valid` and `out_ready` are both high.
- While the sink holds `out_ready` low, the engine holds `out_valid`, `out_data` and `out_last` unchanged.
- The engine never withdraws a byte it has offered.

Status is reported through plain level outputs: a sticky per-descriptor flag, a sticky walk-finished flag, and a kick-pending flag.

Top module: `txd_csum_engine`

## Requirements
- R1: A `kick` pulse seen while idle starts a walk at the current index. Each descriptor whose status bit 31 (owned) is set is processed. The first descriptor read with bit 31 clear ends the walk, and that descriptor is neither processed nor written. Ending a walk sets `st_all_done`, even when no descriptor was processed.
- R2: Each processed descriptor's status word is written back to its own address with bit 31 cleared. The other 31 bits are written back unchanged.
- R3: `ring_reg` holds the ring base in bits [31:8] and the current index in bits [7:0]. A `ring_wr` while idle loads it. Entry i sits at byte address base*256 + 8*i, with the status word at +0 and the fragment address at +4. After each processed descriptor the index steps by one, and it wraps to 0 when it reaches (`ring_size`+1)*16.
- R4: Status bits [12:0] give the fragment length in bytes. Memory is little-endian: the byte at address a is lane a%4 of the word at a with its two low bits cleared. Fragment bytes are appended to the frame in order. Status bit 29 (end of packet) closes the frame, which is then sent on the stream with `out_last` on its final byte. The next frame starts empty.
- R5: A frame holds at most 2048 bytes. A fragment that would overflow is cut to the space left, and later bytes of that frame are dropped.
- R6: Status bit 30 (start of packet) clears the running sum and latches a start offset from bits [19:14] and a stuff offset from bits [27:20]. A fragment whose bit 28 (checksum) is set adds to the sum, and the rules below decide which of its bytes count. A fragment whose bit 28 is clear adds nothing.
  - If the fragment's frame positions cover the start offset, only bytes from that offset onward are summed.
  - Otherwise the whole fragment is summed.
  - Bytes are taken in big-endian pairs, starting at the first summed byte of that fragment. An odd final byte takes the high half, with zero in the low half.
- R7: At end of packet, if bit 28 is set on that descriptor, the sum is folded to 16 bits and inverted. The result is written big-endian before the frame is sent: high byte at the stuff offset, low byte at the next position.
- R8: If `tx_enable` is low at end of packet, the frame is discarded and nothing appears on the stream. Its descriptors are still written back and the index still advances.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values on the next cycle.
- R10: `kick` sets `kick_pending`. Each processed descriptor sets `st_desc_done` and clears `kick_pending`. A walk that processes nothing leaves `kick_pending` set. `status_clr` clears both sticky flags; a flag set in the same cycle stays set.
- R11: After reset, `ring_reg` is 0, all status flags are low, and `out_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kick | input | 1 | Start pulse for a ring walk |
| ring_wr | input | 1 | Load `ring_reg` from `ring_wdata` (honoured while idle) |
| ring_wdata | input | 32 | Ring base [31:8] and index [7:0] to load |
| ring_size | input | 8 | Ring length code; entries = (ring_size+1)*16 |
| tx_enable | input | 1 | Frames are sent only while high |
| status_clr | input | 1 | Clears the sticky status flags |
| ring_reg | output | 32 | Current ring base and index |
| kick_pending | output | 1 | A kick has not yet been consumed by a descriptor |
| st_desc_done | output | 1 | Sticky: a descriptor was processed |
| st_all_done | output | 1 | Sticky: a walk ended |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a word write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| out_valid | output | 1 | Stream byte offered |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Sink accepts the byte |

## Verification
The assertions assume the following about the block's inputs:
- Memory answers every read exactly one cycle later.
- The ring index loaded through `ring_wr` lies inside the ring that `ring_size` defines.
- `ring_size` and `tx_enable` stay constant while a walk is running.
- `ring_wr` is used only when the engine is idle.

The stimulus keeps to these rules. Its memory model returns registered data one cycle after each request. It loads the ring register only between walks, and it uses a 16-entry ring with indices below 16. It changes `tx_enable` only between walks. While checking the stability of the stream under back-pressure, it drives `out_ready` in an irregular pattern.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int DESC_OWN  = 31;
  localparam int DESC_SOP  = 30;
  localparam int DESC_EOP  = 29;
  localparam int DESC_CK   = 28;
  localparam int STUFF_LSB = 20;
  localparam int STUFF_W   = 8;
  localparam int START_LSB = 14;
  localparam int START_W   = 6;
  localparam int LEN_W     = 13;

  typedef struct packed {
    logic               own;
    logic               sop;
    logic               eop;
    logic               ck;
    logic [STUFF_W-1:0] stuff;
    logic [START_W-1:0] start;
    logic [LEN_W-1:0]   len;
  } txd_desc_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_STAT, ST_RD_BUF, ST_CHK, ST_FREQ, ST_FDAT,
    ST_FEND, ST_STUFF_HI, ST_STUFF_LO, ST_EMIT, ST_WB
  } txd_state_e;

  function automatic txd_desc_t txd_decode(input logic [31:0] w);
    txd_desc_t d;
    d.own   = w[DESC_OWN];
    d.sop   = w[DESC_SOP];
    d.eop   = w[DESC_EOP];
    d.ck    = w[DESC_CK];
    d.stuff = w[STUFF_LSB +: STUFF_W];
    d.start = w[START_LSB +: START_W];
    d.len   = w[LEN_W-1:0];
    return d;
  endfunction

endpackage

// File: rtl/txd_stage_buf.sv
module txd_stage_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/txd_csum_acc.sv
module txd_csum_acc #(
  parameter int ACC_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        add_en,
  input  logic        hi_half,
  input  logic [7:0]  data,
  output logic [15:0] result
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] term;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  assign term = hi_half ? ACC_W'({data, 8'h00}) : ACC_W'(data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clr)    acc <= '0;
    else if (add_en) acc <= acc + term;
  end

  assign fold1  = {1'b0, acc[15:0]} + {1'b0, acc[31:16]};
  assign fold2  = fold1[15:0] + {15'd0, fold1[16]};
  assign result = ~fold2;
endmodule

// File: rtl/txd_csum_engine.sv
module txd_csum_engine
  import txd_pkg::*;
#(
  parameter int BUF_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kick,
  input  logic        ring_wr,
  input  logic [31:0] ring_wdata,
  input  logic [7:0]  ring_size,
  input  logic        tx_enable,
  input  logic        status_clr,
  output logic [31:0] ring_reg,
  output logic        kick_pending,
  output logic        st_desc_done,
  output logic        st_all_done,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic        out_ready
);
  localparam int BAW   = $clog2(BUF_BYTES);
  localparam int PW    = BAW + 1;
  localparam int CNT_W = 13;

  txd_state_e   state;
  logic [23:0]  ring_base;
  logic [7:0]   ring_idx;
  logic [31:0]  desc_stat;
  logic [31:0]  frag_addr;
  logic [PW-1:0] frag_len, frag_cnt, pos, ck_first, emit_idx;
  logic [START_W-1:0] start_q;
  logic [STUFF_W-1:0] stuff_q;
  logic [1:0]   lane_q;
  logic         pending_q, desc_flag_q, all_flag_q;

  txd_desc_t    dsc;
  logic [31:0]  desc_addr, fetch_addr;
  logic [15:0]  len16, room16, eff16;
  logic [PW-1:0] len_eff;
  logic [START_W-1:0] eff_start;
  logic         contains;
  logic [CNT_W-1:0] ring_cnt, idx_inc;
  logic [7:0]   idx_next;
  txd_state_e   emit_or_wb;
  logic         emit_last;
  logic [7:0]   fetch_byte;
  logic         buf_we;
  logic [BAW-1:0] buf_waddr;
  logic [7:0]   buf_wdata, buf_rdata;
  logic [15:0]  csum;
  logic         sum_en, sum_hi, sum_clr;

  assign dsc        = txd_decode(desc_stat);
  assign desc_addr  = {ring_base, 8'h00} + {21'd0, ring_idx, 3'b000};
  assign fetch_addr = frag_addr + 32'(frag_cnt);

  // fragment length after clipping to the space left in the staging buffer
  assign len16    = 16'(dsc.len);
  assign room16   = 16'(BUF_BYTES) - 16'(pos);
  assign eff16    = (len16 > room16) ? room16 : len16;
  assign len_eff  = PW'(eff16);
  assign eff_start = dsc.sop ? dsc.start : start_q;
  assign contains = (16'(pos) <= 16'(eff_start)) &&
                    (16'(eff_start) < 16'(pos) + eff16);

  // ring index step with wrap at (size+1)*16 entries
  assign ring_cnt = (CNT_W'(ring_size) + CNT_W'(1)) << 4;
  assign idx_inc  = CNT_W'(ring_idx) + CNT_W'(1);
  assign idx_next = (idx_inc >= ring_cnt) ? 8'd0 : idx_inc[7:0];

  assign emit_or_wb = (tx_enable && pos != '0) ? ST_EMIT : ST_WB;
  assign emit_last  = (emit_idx == pos - PW'(1));
  assign fetch_byte = mem_rdata[8*lane_q +: 8];

  // staging buffer write port: fragment bytes, then the two checksum bytes
  always_comb begin
    buf_we    = 1'b0;
    buf_waddr = pos[BAW-1:0];
    buf_wdata = fetch_byte;
    case (state)
      ST_FDAT: buf_we = 1'b1;
      ST_STUFF_HI: begin
        buf_we    = 1'b1;
        buf_waddr = BAW'(stuff_q);
        buf_wdata = csum[15:8];
      end
      ST_STUFF_LO: begin
        buf_we    = 1'b1;
        buf_waddr = BAW'(stuff_q) + BAW'(1);
        buf_wdata = csum[7:0];
      end
      default: ;
    endcase
  end

  txd_stage_buf #(.DEPTH(BUF_BYTES)) i_stage (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_addr (buf_waddr),
    .wr_data (buf_wdata),
    .rd_addr (emit_idx[BAW-1:0]),
    .rd_data (buf_rdata)
  );

  assign sum_clr = (state == ST_CHK) && dsc.sop;
  assign sum_en  = (state == ST_FDAT) && dsc.ck && (pos >= ck_first);
  assign sum_hi  = ~(pos[0] ^ ck_first[0]);

  txd_csum_acc #(.ACC_W(32)) i_csum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (sum_clr),
    .add_en  (sum_en),
    .hi_half (sum_hi),
    .data    (fetch_byte),
    .result  (csum)
  );

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = desc_stat & ~(32'h1 << DESC_OWN);
    case (state)
      ST_RD_STAT: mem_req = 1'b1;
      ST_RD_BUF: begin
        mem_req  = mem_rdata[DESC_OWN];
        mem_addr = desc_addr + 32'd4;
      end
      ST_FREQ: begin
        mem_req  = 1'b1;
        mem_addr = fetch_addr;
      end
      ST_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      ring_base   <= '0;
      ring_idx    <= '0;
      desc_stat   <= '0;
      frag_addr   <= '0;
      frag_len    <= '0;
      frag_cnt    <= '0;
      pos         <= '0;
      ck_first    <= '0;
      emit_idx    <= '0;
      start_q     <= '0;
      stuff_q     <= '0;
      lane_q      <= '0;
      pending_q   <= 1'b0;
      desc_flag_q <= 1'b0;
      all_flag_q  <= 1'b0;
    end else begin
      if (status_clr) begin
        desc_flag_q <= 1'b0;
        all_flag_q  <= 1'b0;
      end
      if (ring_wr && state == ST_IDLE) begin
        ring_base <= ring_wdata[31:8];
        ring_idx  <= ring_wdata[7:0];
      end
      case (state)
        ST_IDLE: if (kick) begin
          pos   <= '0;
          state <= ST_RD_STAT;
        end
        ST_RD_STAT: state <= ST_RD_BUF;
        ST_RD_BUF: begin
          desc_stat <= mem_rdata;
          if (mem_rdata[DESC_OWN]) state <= ST_CHK;
          else begin
            all_flag_q <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_CHK: begin
          frag_addr <= mem_rdata;
          frag_len  <= len_eff;
          frag_cnt  <= '0;
          ck_first  <= contains ? PW'(eff_start) : pos;
          if (dsc.sop) begin
            start_q <= dsc.start;
            stuff_q <= dsc.stuff;
          end
          state <= (len_eff == '0) ? ST_FEND : ST_FREQ;
        end
        ST_FREQ: begin
          lane_q <= fetch_addr[1:0];
          state  <= ST_FDAT;
        end
        ST_FDAT: begin
          pos      <= pos + PW'(1);
          frag_cnt <= frag_cnt + PW'(1);
          state    <= (frag_cnt + PW'(1) == frag_len) ? ST_FEND : ST_FREQ;
        end
        ST_FEND: begin
          emit_idx <= '0;
          if (!dsc.eop)   state <= ST_WB;
          else if (dsc.ck) state <= ST_STUFF_HI;
          else            state <= emit_or_wb;
        end
        ST_STUFF_HI: state <= ST_STUFF_LO;
        ST_STUFF_LO: state <= emit_or_wb;
        ST_EMIT: if (out_ready) begin
          if (emit_last) state <= ST_WB;
          else emit_idx <= emit_idx + PW'(1);
        end
        ST_WB: begin
          ring_idx    <= idx_next;
          desc_flag_q <= 1'b1;
          pending_q   <= 1'b0;
          if (dsc.eop) pos <= '0;
          state <= ST_RD_STAT;
        end
        default: state <= ST_IDLE;
      endcase
      if (kick) pending_q <= 1'b1;
    end
  end

  assign ring_reg     = {ring_base, ring_idx};
  assign kick_pending = pending_q;
  assign st_desc_done = desc_flag_q;
  assign st_all_done  = all_flag_q;
  assign out_valid    = (state == ST_EMIT);
  assign out_data     = buf_rdata;
  assign out_last     = out_valid && emit_last;
endmodule

// File: rtl/txd_csum_engine_chk.sv
module txd_csum_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ring_size,
  input logic [7:0] ring_index,
  input logic       mem_req,
  input logic       mem_we,
  input logic [2:0] mem_addr_lo,
  input logic       wb_own,
  input logic       st_desc_done,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_ready
);
  assert_hold_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_wb_owner_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !wb_own);

  assert_wb_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr_lo == 3'b000);

  assert_index_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    13'(ring_index) < ((13'(ring_size) + 13'd1) << 4));

  assert_desc_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |=> st_desc_done);

  assert_quiet_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req);
endmodule

bind txd_csum_engine txd_csum_engine_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ring_size    (ring_size),
  .ring_index   (ring_reg[7:0]),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr_lo  (mem_addr[2:0]),
  .wb_own       (mem_wdata[31]),
  .st_desc_done (st_desc_done),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_last     (out_last),
  .out_ready    (out_ready)
);

// File: tb/test_txd_csum_engine.sv
module test_txd_csum_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] SOP = 32'h4000_0000;
  localparam logic [31:0] EOP = 32'h2000_0000;
  localparam logic [31:0] CK  = 32'h1000_0000;
  localparam logic [31:0] RING_AT = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kick = 1'b0, ring_wr = 1'b0, tx_enable = 1'b1, status_clr = 1'b0;
  logic [31:0] ring_wdata = '0;
  logic [7:0]  ring_size = 8'd0;
  logic [31:0] ring_reg;
  logic        kick_pending, st_desc_done, st_all_done;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_last, out_ready;
  logic [7:0]  out_data;

  int checks = 0, errors = 0, seen = 0;
  string cur_req = "R4";
  logic [8:0] exp_q[$];
  logic [7:0] fb [2048];
  logic [7:0] mb [16384];
  logic        tb_we = 1'b0;
  logic [13:0] tb_addr = '0;
  logic [7:0]  tb_byte = '0;
  logic        ready_mode = 1'b0;
  logic [7:0]  lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_csum_engine i_txd_csum_engine (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ring_wr(ring_wr),
    .ring_wdata(ring_wdata), .ring_size(ring_size), .tx_enable(tx_enable),
    .status_clr(status_clr), .ring_reg(ring_reg), .kick_pending(kick_pending),
    .st_desc_done(st_desc_done), .st_all_done(st_all_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );

  // memory model: registered read data one cycle after the request
  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      mb[{mem_addr[13:2], 2'd0}] <= mem_wdata[7:0];
      mb[{mem_addr[13:2], 2'd1}] <= mem_wdata[15:8];
      mb[{mem_addr[13:2], 2'd2}] <= mem_wdata[23:16];
      mb[{mem_addr[13:2], 2'd3}] <= mem_wdata[31:24];
    end
    if (mem_req && !mem_we)
      mem_rdata <= {mb[{mem_addr[13:2], 2'd3}], mb[{mem_addr[13:2], 2'd2}],
                    mb[{mem_addr[13:2], 2'd1}], mb[{mem_addr[13:2], 2'd0}]};
    if (tb_we) mb[tb_addr] <= tb_byte;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 8'hA5;
      out_ready <= 1'b1;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= ready_mode ? lfsr[0] : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted stream byte
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected stream byte", {23'd0, out_last, out_data}, 32'h0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({out_last, out_data} == e, cur_req, "stream byte",
            {23'd0, out_last, out_data}, {23'd0, e});
      end
    end
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
    summary_and_end();
  end

  task automatic poke8(input logic [31:0] a, input logic [7:0] v);
    tb_we = 1'b1; tb_addr = a[13:0]; tb_byte = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic poke32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) poke8(a + 32'(k), v[8*k +: 8]);
  endtask

  function automatic logic [31:0] peek32(input logic [31:0] a);
    return {mb[a[13:0]+14'd3], mb[a[13:0]+14'd2], mb[a[13:0]+14'd1], mb[a[13:0]]};
  endfunction

  task automatic set_desc(input int idx, input logic [31:0] st, input logic [31:0] ba);
    poke32(RING_AT + 32'(idx * 8), st);
    poke32(RING_AT + 32'(idx * 8) + 32'd4, ba);
  endtask

  task automatic load_frag(input logic [31:0] a, input int from, input int n);
    for (int k = 0; k < n; k++) poke8(a + 32'(k), fb[from + k]);
  endtask

  task automatic push_frame(input int n);
    for (int k = 0; k < n; k++) exp_q.push_back({k == n - 1, fb[k]});
  endtask

  function automatic logic [31:0] sum_range(input int from, input int to_x);
    logic [31:0] s = 0;
    for (int k = from; k < to_x; k += 2) begin
      s += {16'd0, fb[k], 8'h00};
      if (k + 1 < to_x) s += {24'd0, fb[k + 1]};
    end
    return s;
  endfunction

  function automatic logic [15:0] finish_sum(input logic [31:0] s);
    logic [31:0] t = (s & 32'hFFFF) + (s >> 16);
    t = (t & 32'hFFFF) + (t >> 16);
    return ~t[15:0];
  endfunction

  task automatic run_walk();
    status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    for (int w = 0; w < 40000 && !st_all_done; w++) @(negedge clk);
    chk(st_all_done, "R1", "walk end flag", {31'd0, st_all_done}, 32'h1);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, cur_req, "frames left undelivered", exp_q.size(), 32'h0);
  endtask

  initial begin
    logic [31:0] s;
    logic [15:0] c;
    int seen0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(ring_reg == 0, "R11", "ring_reg after reset", ring_reg, 32'h0);
    chk(!st_desc_done && !st_all_done && !kick_pending, "R11", "flags after reset",
        {29'd0, kick_pending, st_desc_done, st_all_done}, 32'h0);
    chk(!out_valid && !mem_req, "R11", "outputs after reset",
        {30'd0, out_valid, mem_req}, 32'h0);

    ring_wr = 1'b1; ring_wdata = 32'h0000_0100; @(negedge clk); ring_wr = 1'b0;
    chk(ring_reg == 32'h100, "R3", "ring_reg load", ring_reg, 32'h100);

    // single-fragment frame, no checksum (R4)
    cur_req = "R4";
    for (int i = 0; i < 20; i++) fb[i] = 8'(i * 5 + 1);
    load_frag(32'h400, 0, 20);
    set_desc(0, OWN | SOP | EOP | 32'd20, 32'h400);
    set_desc(1, 32'h0, 32'h0);
    push_frame(20);
    run_walk();
    chk(peek32(RING_AT) == (SOP | EOP | 32'd20), "R2", "writeback desc0",
        peek32(RING_AT), SOP | EOP | 32'd20);
    chk(ring_reg == 32'h101, "R3", "index after one", ring_reg, 32'h101);
    chk(st_desc_done, "R10", "desc flag", {31'd0, st_desc_done}, 32'h1);
    chk(!kick_pending, "R10", "pending cleared", {31'd0, kick_pending}, 32'h0);

    // three fragments, checksum from offset 12, stuffed at 4, back-pressure (R6 R7 R9)
    cur_req = "R6 R7 R9";
    ready_mode = 1'b1;
    for (int i = 0; i < 26; i++) fb[i] = 8'(i * 13 + 5);
    load_frag(32'h503, 0, 10);
    load_frag(32'h601, 10, 7);
    load_frag(32'h700, 17, 9);
    set_desc(1, OWN | SOP | (32'd4 << 20) | (32'd12 << 14) | 32'd10, 32'h503);
    set_desc(2, OWN | CK | 32'd7, 32'h601);
    set_desc(3, OWN | CK | EOP | 32'd9, 32'h700);
    set_desc(4, 32'h0, 32'h0);
    s = sum_range(12, 17) + sum_range(17, 26);
    c = finish_sum(s);
    fb[4] = c[15:8];
    fb[5] = c[7:0];
    push_frame(26);
    run_walk();
    chk(ring_reg == 32'h104, "R3", "index after frame", ring_reg, 32'h104);
    chk(peek32(RING_AT + 32'd24) == (CK | EOP | 32'd9), "R2", "writeback desc3",
        peek32(RING_AT + 32'd24), CK | EOP | 32'd9);

    // truncation at 2048 bytes (R5)
    cur_req = "R5";
    for (int i = 0; i < 2000; i++) fb[i] = 8'(i * 7 + 3);
    load_frag(32'h1000, 0, 2000);
    for (int j = 0; j < 100; j++) fb[j] = 8'(j * 11 + 9);
    load_frag(32'h2000, 0, 100);
    for (int j = 0; j < 48; j++) fb[2000 + j] = fb[j];
    for (int i = 0; i < 2000; i++) fb[i] = 8'(i * 7 + 3);
    set_desc(4, OWN | SOP | 32'd2000, 32'h1000);
    set_desc(5, OWN | EOP | 32'd100, 32'h2000);
    set_desc(6, 32'h0, 32'h0);
    seen0 = seen;
    push_frame(2048);
    run_walk();
    chk(seen - seen0 == 2048, "R5", "bytes emitted", seen - seen0, 32'd2048);
    chk(ring_reg == 32'h106, "R3", "index after long frame", ring_reg, 32'h106);
    ready_mode = 1'b0;

    // transmit disabled: frame dropped, descriptor still consumed (R8)
    cur_req = "R8";
    tx_enable = 1'b0;
    for (int i = 0; i < 8; i++) fb[i] = 8'(200 + i);
    load_frag(32'h400, 0, 8);
    set_desc(6, OWN | SOP | EOP | 32'd8, 32'h400);
    set_desc(7, 32'h0, 32'h0);
    seen0 = seen;
    run_walk();
    chk(seen == seen0, "R8", "no bytes while disabled", seen - seen0, 32'h0);
    chk(peek32(RING_AT + 32'd48) == (SOP | EOP | 32'd8), "R8", "desc6 written back",
        peek32(RING_AT + 32'd48), SOP | EOP | 32'd8);
    chk(ring_reg == 32'h107, "R8", "index advanced", ring_reg, 32'h107);
    tx_enable = 1'b1;

    // kick with nothing owned (R1 R10)
    cur_req = "R1";
    run_walk();
    chk(!st_desc_done, "R1", "no descriptor processed", {31'd0, st_desc_done}, 32'h0);
    chk(kick_pending, "R10", "pending kept on empty walk", {31'd0, kick_pending}, 32'h1);
    chk(ring_reg == 32'h107, "R1", "index unchanged", ring_reg, 32'h107);

    // wraparound from index 15 of a 16-entry ring (R3)
    cur_req = "R3";
    ring_wr = 1'b1; ring_wdata = 32'h0000_010F; @(negedge clk); ring_wr = 1'b0;
    for (int i = 0; i < 6; i++) fb[i] = 8'(i + 40);
    load_frag(32'h400, 0, 6);
    set_desc(15, OWN | SOP | EOP | 32'd6, 32'h400);
    push_frame(6);
    for (int i = 0; i < 5; i++) fb[i] = 8'(i + 90);
    load_frag(32'h481, 0, 5);
    set_desc(0, OWN | SOP | EOP | 32'd5, 32'h481);
    set_desc(1, 32'h0, 32'h0);
    push_frame(5);
    run_walk();
    chk(ring_reg == 32'h101, "R3", "index after wrap", ring_reg, 32'h101);
    chk(peek32(RING_AT + 32'd120) == (SOP | EOP | 32'd6), "R2", "writeback desc15",
        peek32(RING_AT + 32'd120), SOP | EOP | 32'd6);
    chk(!kick_pending, "R10", "pending cleared after wrap walk", {31'd0, kick_pending}, 32'h0);

    summary_and_end();
  end
endmodule